// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter with Justification and Slot Offset

This block turns one stereo PCM sample pair per frame into a serial bit stream on a single data line. Both the bit clock and the word clock come from elsewhere in the system. The block samples them with its own system clock and puts out one data bit at every launch edge of the bit clock. The word clock marks the channel: the left channel occupies the half-frame where the word clock is high, and the right channel the half where it is low. Each half-frame is `cfg_half_bits` bit slots long.

Two placements of the data are available.
- Right-justified: the LSB of each channel sits in the last slot before the next word-clock edge.
- Offset: the MSB starts a programmable number of bit slots after the word-clock edge.

The block can release the data line during slots that carry no sample bits. Several transmitters can then share one line, each placed at its own offset, to form a time-division multiplexed bus.

Samples enter on a valid/ready stream. `s_ready` is high for exactly one system-clock cycle, the cycle in which the block sees the launch edge that opens a new frame. A pair moves only when `s_valid` and `s_ready` are both high in that cycle. While `s_valid` is high the producer must hold `s_left` and `s_right` stable. If no pair is offered at a frame start, the frame carries silence, with every sample bit zero. The block never stalls the bit clock. Back-pressure therefore means that a producer waits at most one frame for its pair to be taken.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is held low and after its release, until the first frame starts, `sd_out`, `sd_oe`, `err_frame` and `s_ready` are all 0.
- R2: A launch edge is a falling `bclk` when `cfg_bclk_inv` is 0 and a rising `bclk` when it is 1. `sd_out` and `sd_oe` change only in the system-clock cycle after the cycle in which the block samples a launch edge. Between launch edges they hold.
- R3: The slot count restarts at 0 at every launch edge where `wclk` differs from its level at the previous launch edge, and otherwise rises by one. A frame starts at a launch edge where `wclk` is found high after being low. The `wclk` level after reset is taken as high, so the output stays off until the first such rise.
- R4: The word-length code in `cfg_wlen` gives 00 = 16, 01 = 20, 10 = 24 and 11 = 32 bits. The sample occupies the low bits of `s_left` or `s_right` and is sent MSB first.
- R5: `cfg_fmt` = 2'b10 selects right-justified placement. Data starts at slot `cfg_half_bits` minus the word length, so the LSB falls in the last slot of each half-frame.
- R6: `cfg_fmt` = 2'b00 selects offset placement. The MSB goes in slot `cfg_offset` of each half-frame.
- R7: `cfg_fmt` values 2'b01 and 2'b11 are reserved. A frame started with either value keeps `sd_oe` and `sd_out` at 0, and `err_frame` stays 0.
- R8: Slots outside the data window carry `sd_out` = 0. `sd_oe` is 0 in those slots when `cfg_hiz_idle` is 1 and 1 when it is 0. Data slots always have `sd_oe` = 1.
- R9: `s_ready` is 1 only in the cycle in which a frame-start launch edge is seen. A frame that opens without `s_valid` sends zeros in its data slots.
- R10: The sample pair and all `cfg_*` inputs except `cfg_bclk_inv` are captured at frame start. Changes made during a frame do not affect that frame.
- R11: At frame start, `err_frame` is set for the whole frame if the placement does not fit: right-justified with a half-frame shorter than the word length, or offset placement with offset plus word length greater than the half-frame. `err_frame` is cleared at the next frame start whose placement fits, and during an erroneous frame `sd_oe` and `sd_out` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock, synchronous to `clk` |
| wclk | input | 1 | Word clock; high = left half |
| cfg_fmt | input | 2 | Placement: 00 offset, 10 right-justified, others reserved |
| cfg_wlen | input | 2 | Word-length code |
| cfg_offset | input | SLOT_W | First data slot in offset placement |
| cfg_half_bits | input | SLOT_W | Bit slots per half-frame |
| cfg_bclk_inv | input | 1 | Launch on rising instead of falling bit clock |
| cfg_hiz_idle | input | 1 | Release the line in slots without data |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Sample pair taken this cycle |
| s_left | input | SAMPLE_W | Left sample, right-aligned |
| s_right | input | SAMPLE_W | Right sample, right-aligned |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Output enable for the data line |
| err_frame | output | 1 | Current frame placement does not fit |

## Verification
The bench targets four corner cases.
- Window edges. A design with an off-by-one start computes would show the LSB one slot early or late, or lose it across the word-clock edge, most visibly at 32-bit words in a 32-slot half-frame and at an offset that exactly fills the half.
- Polarity switch. When the bit-clock polarity flips during a run, a design that counted the wrong edge would shift its slot numbering.
- Mid-frame changes. Word-length and idle-release changes made during a frame must wait for the next frame start; a design that used live settings would alter the frame in progress.
- Overflow and silence. Placements that overflow the half-frame must silence the line with the error flag set; frames opened with no offered pair must send zeros; a design that reused the last pair would repeat stale audio.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [1:0] {
    FMT_OFFSET = 2'b00,
    FMT_RSV_A  = 2'b01,
    FMT_RJUST  = 2'b10,
    FMT_RSV_B  = 2'b11
  } ser_fmt_e;

  localparam int unsigned WL_W = 6;

  function automatic logic [WL_W-1:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   return WL_W'(16);
      2'b01:   return WL_W'(20);
      2'b10:   return WL_W'(24);
      default: return WL_W'(32);
    endcase
  endfunction

  function automatic logic fmt_is_live(input ser_fmt_e f);
    return (f == FMT_OFFSET) || (f == FMT_RJUST);
  endfunction

endpackage

// File: rtl/aud_ser_edge.sv
module aud_ser_edge #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              wclk,
  input  logic              bclk_inv,
  output logic              launch,
  output logic              frame_start,
  output logic [SLOT_W-1:0] slot_now
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

  logic              bclk_q;
  logic              wclk_last;
  logic [SLOT_W-1:0] slot_q;
  logic              new_half;

  always_comb begin
    if (bclk_inv) launch = bclk & ~bclk_q;
    else          launch = ~bclk & bclk_q;
  end

  assign new_half    = launch && (wclk != wclk_last);
  assign frame_start = new_half && wclk;

  always_comb begin
    if (new_half)              slot_now = '0;
    else if (slot_q == SLOT_MAX) slot_now = slot_q;
    else                       slot_now = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      wclk_last <= 1'b1;
      slot_q    <= '0;
    end else begin
      bclk_q <= bclk;
      if (launch) begin
        wclk_last <= wclk;
        slot_q    <= slot_now;
      end
    end
  end

  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (slot_q == '0)); // R3

  AST_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(slot_q)); // R2

endmodule

// File: rtl/aud_ser_latch.sv
module aud_ser_latch
  import aud_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32,
  parameter int unsigned SLOT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_wlen,
  input  logic [SLOT_W-1:0]   cfg_offset,
  input  logic [SLOT_W-1:0]   cfg_half_bits,
  input  logic                cfg_hiz_idle,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output ser_fmt_e            eff_fmt,
  output logic [WL_W-1:0]     eff_wl,
  output logic [SLOT_W-1:0]   eff_off,
  output logic [SLOT_W-1:0]   eff_hb,
  output logic                eff_hiz,
  output logic                eff_err,
  output logic                eff_framed,
  output logic [SAMPLE_W-1:0] eff_left,
  output logic [SAMPLE_W-1:0] eff_right,
  output logic                err_q
);
  localparam int unsigned SW = SLOT_W + 1;

  ser_fmt_e          fmt_q;
  logic [WL_W-1:0]   wl_q;
  logic [SLOT_W-1:0] off_q, hb_q;
  logic              hiz_q, framed_q;

  logic [WL_W-1:0]   wl_in;
  logic              err_in;
  logic [SW-1:0]     wl_x, off_x, hb_x;

  assign wl_in = wlen_bits(cfg_wlen);
  assign wl_x  = SW'(wl_in);
  assign off_x = SW'(cfg_offset);
  assign hb_x  = SW'(cfg_half_bits);

  always_comb begin
    case (ser_fmt_e'(cfg_fmt))
      FMT_RJUST:  err_in = hb_x < wl_x;
      FMT_OFFSET: err_in = (off_x + wl_x) > hb_x;
      default:    err_in = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q    <= FMT_RSV_A;
      wl_q     <= WL_W'(16);
      off_q    <= '0;
      hb_q     <= '0;
      hiz_q    <= 1'b0;
      err_q    <= 1'b0;
      framed_q <= 1'b0;
    end else if (frame_start) begin
      fmt_q    <= ser_fmt_e'(cfg_fmt);
      wl_q     <= wl_in;
      off_q    <= cfg_offset;
      hb_q     <= cfg_half_bits;
      hiz_q    <= cfg_hiz_idle;
      err_q    <= err_in;
      framed_q <= 1'b1;
    end
  end

  // one holding register per channel
  logic [SAMPLE_W-1:0] samp_in [2];
  logic [SAMPLE_W-1:0] samp_q  [2];
  logic [SAMPLE_W-1:0] samp_eff[2];

  assign samp_in[0] = s_left;
  assign samp_in[1] = s_right;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)           samp_q[ch] <= '0;
      else if (frame_start) samp_q[ch] <= s_valid ? samp_in[ch] : '0;
    end
    assign samp_eff[ch] = frame_start ? (s_valid ? samp_in[ch] : '0) : samp_q[ch];
  end

  assign eff_left   = samp_eff[0];
  assign eff_right  = samp_eff[1];
  assign eff_fmt    = frame_start ? ser_fmt_e'(cfg_fmt) : fmt_q;
  assign eff_wl     = frame_start ? wl_in         : wl_q;
  assign eff_off    = frame_start ? cfg_offset    : off_q;
  assign eff_hb     = frame_start ? cfg_half_bits : hb_q;
  assign eff_hiz    = frame_start ? cfg_hiz_idle  : hiz_q;
  assign eff_err    = frame_start ? err_in        : err_q;
  assign eff_framed = frame_start | framed_q;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(wl_q) && $stable(fmt_q) && $stable(hiz_q))); // R10

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(err_q)); // R11

endmodule

// File: rtl/aud_ser_slot.sv
module aud_ser_slot
  import aud_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32,
  parameter int unsigned SLOT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                left_half,
  input  logic [SLOT_W-1:0]   slot_now,
  input  ser_fmt_e            eff_fmt,
  input  logic [WL_W-1:0]     eff_wl,
  input  logic [SLOT_W-1:0]   eff_off,
  input  logic [SLOT_W-1:0]   eff_hb,
  input  logic                eff_hiz,
  input  logic                eff_err,
  input  logic                eff_framed,
  input  logic [SAMPLE_W-1:0] eff_left,
  input  logic [SAMPLE_W-1:0] eff_right,
  output logic                sd_out,
  output logic                sd_oe
);
  localparam int unsigned SW    = SLOT_W + 1;
  localparam int unsigned IDX_W = $clog2(SAMPLE_W);

  logic [SW-1:0]       wl_x, slot_x, start, rel, idx_full;
  logic [IDX_W-1:0]    idx;
  logic                in_win, silent;
  logic [SAMPLE_W-1:0] word;
  logic                sd_nxt, oe_nxt;

  assign wl_x   = SW'(eff_wl);
  assign slot_x = SW'(slot_now);
  assign start  = (eff_fmt == FMT_RJUST) ? (SW'(eff_hb) - wl_x) : SW'(eff_off);
  assign in_win = (slot_x >= start) && (slot_x < (start + wl_x));
  assign rel      = slot_x - start;
  assign idx_full = wl_x - SW'(1) - rel;
  assign idx      = idx_full[IDX_W-1:0];
  assign word     = left_half ? eff_left : eff_right;
  assign silent   = !eff_framed || eff_err || !fmt_is_live(eff_fmt);

  always_comb begin
    if (silent) begin
      sd_nxt = 1'b0;
      oe_nxt = 1'b0;
    end else if (in_win) begin
      sd_nxt = word[idx];
      oe_nxt = 1'b1;
    end else begin
      sd_nxt = 1'b0;
      oe_nxt = !eff_hiz;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (launch) begin
      sd_out <= sd_nxt;
      sd_oe  <= oe_nxt;
    end
  end

  AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out); // R8

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32,
  parameter int unsigned SLOT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                wclk,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_wlen,
  input  logic [SLOT_W-1:0]   cfg_offset,
  input  logic [SLOT_W-1:0]   cfg_half_bits,
  input  logic                cfg_bclk_inv,
  input  logic                cfg_hiz_idle,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                sd_out,
  output logic                sd_oe,
  output logic                err_frame
);
  logic              launch, frame_start;
  logic [SLOT_W-1:0] slot_now;
  ser_fmt_e          eff_fmt;
  logic [WL_W-1:0]   eff_wl;
  logic [SLOT_W-1:0] eff_off, eff_hb;
  logic              eff_hiz, eff_err, eff_framed;
  logic [SAMPLE_W-1:0] eff_left, eff_right;

  aud_ser_edge #(.SLOT_W(SLOT_W)) edge_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .bclk_inv(cfg_bclk_inv),
    .launch(launch), .frame_start(frame_start), .slot_now(slot_now)
  );

  aud_ser_latch #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) latch_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_offset(cfg_offset),
    .cfg_half_bits(cfg_half_bits), .cfg_hiz_idle(cfg_hiz_idle),
    .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .eff_fmt(eff_fmt), .eff_wl(eff_wl), .eff_off(eff_off), .eff_hb(eff_hb),
    .eff_hiz(eff_hiz), .eff_err(eff_err), .eff_framed(eff_framed),
    .eff_left(eff_left), .eff_right(eff_right), .err_q(err_frame)
  );

  aud_ser_slot #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .left_half(wclk), .slot_now(slot_now),
    .eff_fmt(eff_fmt), .eff_wl(eff_wl), .eff_off(eff_off), .eff_hb(eff_hb),
    .eff_hiz(eff_hiz), .eff_err(eff_err), .eff_framed(eff_framed),
    .eff_left(eff_left), .eff_right(eff_right), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  assign s_ready = frame_start;

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |-> (!sd_oe && !sd_out)); // R11

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($stable(sd_out) && $stable(sd_oe))); // R2

  AST_READY_IN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> wclk); // R9

endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0;
  logic [1:0] cfg_fmt = 2'b10, cfg_wlen = 2'b00;
  logic [7:0] cfg_offset = '0, cfg_half_bits = 8'd24;
  logic cfg_bclk_inv = 1'b0, cfg_hiz_idle = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic [31:0] s_left = '0, s_right = '0;
  logic sd_out, sd_oe, err_frame;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_offset(cfg_offset),
    .cfg_half_bits(cfg_half_bits), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_hiz_idle(cfg_hiz_idle), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .sd_out(sd_out), .sd_oe(sd_oe),
    .err_frame(err_frame)
  );

  // pending settings, applied only inside step()
  logic [1:0] c_fmt = 2'b10, c_wlen = 2'b00;
  int c_off = 0, c_hb = 24;
  logic c_inv = 1'b0, c_hiz = 1'b0;
  int mid_slot = -1;

  logic [63:0] sq[$];
  int vectors = 0, misses = 0, pushed = 0;
  string phase = "R1";

  // reference model state
  logic m_pb = 1'b0, m_lw = 1'b1, m_framed = 1'b0, m_err = 1'b0, m_hiz = 1'b0;
  logic [1:0] m_fmt = 2'b01, m_wlen = 2'b00;
  int m_off = 0, m_hb = 0, m_slot = 0;
  logic [31:0] m_l = '0, m_r = '0;
  logic e_sd = 1'b0, e_oe = 1'b0, e_rdy = 1'b0;

  function automatic int wl_of(input logic [1:0] c);
    case (c)
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      pushed++;
      sq.push_back({32'(pushed) * 32'h9E3779B1 ^ 32'h5A5A1234,
                    32'(pushed) * 32'h7F4A7C15 ^ 32'hC3A50F0F});
    end
  endtask

  task automatic step(input logic b, input logic w);
    int wl, st;
    logic launch;
    @(negedge clk);
    cmp(phase, "sd_out", sd_out, e_sd);
    cmp(phase, "sd_oe", sd_oe, e_oe);
    cmp("R11", "err_frame", err_frame, m_err);
    bclk = b; wclk = w;
    cfg_fmt = c_fmt; cfg_wlen = c_wlen; cfg_offset = 8'(c_off);
    cfg_half_bits = 8'(c_hb); cfg_bclk_inv = c_inv; cfg_hiz_idle = c_hiz;
    s_valid = (sq.size() > 0);
    s_left  = s_valid ? sq[0][63:32] : 32'hDEAD_0000;
    s_right = s_valid ? sq[0][31:0]  : 32'h0000_BEEF;
    launch = c_inv ? (b && !m_pb) : (!b && m_pb);
    m_pb = b;
    e_rdy = 1'b0;
    if (launch) begin
      if (w != m_lw) begin
        m_slot = 0;
        if (w) begin
          e_rdy = 1'b1;
          m_framed = 1'b1;
          m_fmt = c_fmt; m_wlen = c_wlen; m_off = c_off; m_hb = c_hb; m_hiz = c_hiz;
          m_l = s_valid ? s_left : '0;
          m_r = s_valid ? s_right : '0;
          if (s_valid) void'(sq.pop_front());
          wl = wl_of(m_wlen);
          if (m_fmt == 2'b10)      m_err = (m_hb < wl);
          else if (m_fmt == 2'b00) m_err = (m_off + wl > m_hb);
          else                     m_err = 1'b0;
        end
      end else if (m_slot < 255) m_slot++;
      m_lw = w;
      if (!m_framed || m_err || m_fmt == 2'b01 || m_fmt == 2'b11) begin
        e_sd = 1'b0; e_oe = 1'b0;
      end else begin
        wl = wl_of(m_wlen);
        st = (m_fmt == 2'b10) ? (m_hb - wl) : m_off;
        if (m_slot >= st && m_slot < st + wl) begin
          e_oe = 1'b1;
          e_sd = w ? m_l[wl - 1 - (m_slot - st)] : m_r[wl - 1 - (m_slot - st)];
        end else begin
          e_oe = !m_hiz; e_sd = 1'b0;
        end
      end
    end
    #1;
    cmp("R9", "s_ready", s_ready, e_rdy);
  endtask

  task automatic run_frames(input int n, input int h);
    for (int f = 0; f < n; f++) begin
      for (int hv = 1; hv >= 0; hv--) begin
        for (int s = 0; s < h; s++) begin
          if (hv == 1 && s == mid_slot) begin
            c_wlen = 2'(c_wlen + 2'd1);
            c_hiz = !c_hiz;
          end
          for (int k = 0; k < PH; k++) step(c_inv, 1'(hv));
          for (int k = 0; k < PH; k++) step(!c_inv, 1'(hv));
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "sd_out", sd_out, 1'b0);
    cmp("R1", "sd_oe", sd_oe, 1'b0);
    cmp("R1", "err_frame", err_frame, 1'b0);
    cmp("R1", "s_ready", s_ready, 1'b0);
    rst_n = 1'b1;

    phase = "R3 R4 R5 right-justified";
    push_n(12);
    run_frames(3, 24);
    c_wlen = 2'b01; run_frames(2, 24);
    c_wlen = 2'b10; run_frames(2, 24);
    c_wlen = 2'b11; c_hb = 32; run_frames(2, 32);

    phase = "R6 offset placement";
    c_fmt = 2'b00; c_wlen = 2'b00; c_hb = 20; c_off = 1; push_n(6);
    run_frames(2, 20);
    c_off = 4; run_frames(2, 20);
    c_off = 0; c_wlen = 2'b01; run_frames(1, 20);

    phase = "R8 idle release";
    c_hiz = 1'b1; c_wlen = 2'b00; c_off = 2; push_n(4);
    run_frames(2, 20);
    c_fmt = 2'b10; run_frames(2, 20);
    c_hiz = 1'b0;

    phase = "R2 inverted bit clock";
    c_inv = 1'b1; push_n(5);
    run_frames(3, 20);
    c_inv = 1'b0; run_frames(2, 20);

    phase = "R7 reserved format";
    c_fmt = 2'b01; run_frames(1, 20);
    c_fmt = 2'b11; run_frames(1, 20);

    phase = "R9 silence without valid";
    sq.delete();
    c_fmt = 2'b10; c_wlen = 2'b00;
    run_frames(2, 20);

    phase = "R10 mid-frame change";
    push_n(4); mid_slot = 5;
    run_frames(3, 20);
    mid_slot = -1; c_hiz = 1'b0;

    phase = "R11 overflow";
    c_fmt = 2'b10; c_wlen = 2'b10; push_n(6);
    run_frames(2, 20);
    c_fmt = 2'b00; c_wlen = 2'b00; c_off = 8;
    run_frames(2, 20);
    c_off = 0; run_frames(1, 20);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule